// File: doc/BRIEF.md
# Machine Trap and CSR Write-Back Unit

This block holds the machine-mode trap state of a 32-bit RISC-V core and applies every change to it. The execute stage hands it three kinds of event. A trap request carries a cause code, the PC of the faulting instruction and candidate trap values. An mret request returns from a handler. A CSR access carries a 12-bit address, a write flag and write data. In response the block updates the cause, exception PC, trap value and second trap value registers and the status bits. For a CSR access it returns read data in the same cycle, or it flags the access as an illegal instruction so that the core can raise cause 2.

The trap value depends on the cause. Access faults record the faulting address. Illegal instructions record the instruction bits, and a compressed instruction records only its low half. Software-check traps record the subtype. Breakpoints and all other causes record zero. The status word has a double-trap bit. A trap taken while that bit is set copies its cause into the second trap value register and raises a sticky halt. The machine counter addresses are aliases of the user counter storage. The user counter addresses can only be read.

Top module: `mtrap_csr_unit`

## Requirements
- R1: After reset the machine status (0x300) and status-high (0x310) registers read 0, the vector register (0x305) reads the RESET_VEC parameter, and `halted` is 0.
- R2: A trap request updates the registers at the next clock edge. The exception PC (0x341) takes `trap_pc`, the cause (0x342) takes `trap_cause` zero-extended, MPIE takes the old MIE, and MIE becomes 0.
- R3: For causes 1, 5 and 7 the trap value register (0x343) takes `trap_addr`.
- R4: For cause 2 the trap value takes `trap_insn`. When `trap_insn_c` is 1 it takes only bits 15:0 of `trap_insn`, zero-extended.
- R5: For cause 18 the trap value takes `trap_sub`. For cause 3 and for every cause not named in R3 or R4 it takes 0.
- R6: A trap taken while MDT is 0 sets MDT. A trap taken while MDT is 1 writes its cause to the second trap value register (0x34B) and sets `halted`. `halted` then stays 1 until reset, whatever mret or CSR traffic follows.
- R7: mret clears MDT, copies MPIE into MIE, sets MPIE to 1 and sets MPP to 3.
- R8: A write to 0xC00-0xC02, 0xC80-0xC82 or 0xF11-0xF15 asserts `csr_illegal` in the same cycle and changes no state. Reads of 0xF11-0xF15 return 0 and are legal.
- R9: An access, read or write, to an address that is not implemented asserts `csr_illegal`. Its read data is 0 and it changes no state.
- R10: Addresses 0xB00, 0xB02, 0xB80 and 0xB82 are writable aliases of 0xC00, 0xC02, 0xC80 and 0xC82. A value written through an alias reads back at the user counter address.
- R11: Status bit layout:
  - mstatus (0x300): MIE at bit 3, MPIE at bit 7, MPP at bits 12:11.
  - mstatush (0x310): MBE at bit 5, saved-ELP at bit 9, MDT at bit 10.
  - All other bits of both registers read 0.
- R12: `vec_mode` equals bits 1:0 of the vector register, and `vec_base` equals the vector register with those two bits cleared.
- R13: When events coincide in one cycle, a trap takes precedence over mret, and mret takes precedence over a CSR write. The write that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_cause | input | 5 | Exception cause code |
| trap_pc | input | 32 | PC of the trapping instruction |
| trap_addr | input | 32 | Faulting address for access faults |
| trap_insn | input | 32 | Instruction bits for illegal-instruction traps |
| trap_insn_c | input | 1 | The instruction is compressed (16-bit) |
| trap_sub | input | 32 | Subtype for software-check traps |
| mret_req | input | 1 | Return from trap this cycle |
| csr_valid | input | 1 | CSR access this cycle |
| csr_write | input | 1 | The access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| csr_illegal | output | 1 | The access must raise an illegal-instruction trap |
| st_mie | output | 1 | Current MIE bit |
| st_mpie | output | 1 | Current MPIE bit |
| st_mdt | output | 1 | Current double-trap bit |
| vec_base | output | 32 | Trap vector base |
| vec_mode | output | 2 | Trap vector mode |
| halted | output | 1 | Sticky fatal double-trap indication |

## Verification
The bench sets RESET_VEC to 0x0000_0A05. With that value the vector outputs already show a non-zero mode (1) and a base of 0xA04 straight out of reset, so R12 is checked before any software write to the vector register. COMPRESSED_EN keeps its default of 1, which enables the 16-bit truncation of the trap value for compressed illegal instructions. With that path enabled, the same instruction word is checked twice, once with `trap_insn_c` set and once with it clear. The double-trap sequence is run to a halt and then through mret and reset, so that the stickiness of `halted` can be seen at the ports.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
    localparam int XLEN    = 32;
    localparam int CAUSE_W = 5;
    localparam int ADDR_W  = 12;

    // exception causes that shape the trap value
    localparam logic [CAUSE_W-1:0] EXC_FETCH_ACC = 5'd1;
    localparam logic [CAUSE_W-1:0] EXC_ILLEGAL   = 5'd2;
    localparam logic [CAUSE_W-1:0] EXC_BREAK     = 5'd3;
    localparam logic [CAUSE_W-1:0] EXC_LOAD_ACC  = 5'd5;
    localparam logic [CAUSE_W-1:0] EXC_STORE_ACC = 5'd7;
    localparam logic [CAUSE_W-1:0] EXC_SW_CHECK  = 5'd18;

    // status bit positions
    localparam int ST_MIE_B   = 3;
    localparam int ST_MPIE_B  = 7;
    localparam int ST_MPP_LSB = 11;
    localparam int STH_MBE_B  = 5;
    localparam int STH_ELP_B  = 9;
    localparam int STH_MDT_B  = 10;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_STATUS,
        REG_STATUSH,
        REG_VECTOR,
        REG_SCRATCH,
        REG_EPC,
        REG_CAUSE,
        REG_TVAL,
        REG_TVAL2,
        REG_CYC_LO,
        REG_CYC_HI,
        REG_RET_LO,
        REG_RET_HI,
        REG_INFO
    } csr_reg_e;

    typedef struct packed {
        logic            mie;
        logic            mpie;
        logic [1:0]      mpp;
        logic            mbe;
        logic            mpelp;
        logic            mdt;
        logic            halted;
        logic [XLEN-1:0] vector;
        logic [XLEN-1:0] scratch;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] tval;
        logic [XLEN-1:0] tval2;
        logic [XLEN-1:0] cyc_lo;
        logic [XLEN-1:0] cyc_hi;
        logic [XLEN-1:0] ret_lo;
        logic [XLEN-1:0] ret_hi;
    } trap_state_t;
endpackage

// File: rtl/mtrap_csr_decode.sv
module mtrap_csr_decode
    import mtrap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output csr_reg_e          reg_sel,
    output logic              writable,
    output logic              illegal
);
    logic              aliased;
    logic [ADDR_W-1:0] eff_addr;

    // machine counter addresses map onto user counter storage
    always_comb begin
        aliased  = (addr == 12'hB00) || (addr == 12'hB02) ||
                   (addr == 12'hB80) || (addr == 12'hB82);
        eff_addr = aliased ? (addr + 12'h100) : addr;
    end

    always_comb begin
        reg_sel  = REG_NONE;
        writable = 1'b1;
        case (eff_addr)
            12'h300: reg_sel = REG_STATUS;
            12'h310: reg_sel = REG_STATUSH;
            12'h305: reg_sel = REG_VECTOR;
            12'h340: reg_sel = REG_SCRATCH;
            12'h341: reg_sel = REG_EPC;
            12'h342: reg_sel = REG_CAUSE;
            12'h343: reg_sel = REG_TVAL;
            12'h34B: reg_sel = REG_TVAL2;
            12'hC00: begin reg_sel = REG_CYC_LO; writable = aliased; end
            12'hC02: begin reg_sel = REG_RET_LO; writable = aliased; end
            12'hC80: begin reg_sel = REG_CYC_HI; writable = aliased; end
            12'hC82: begin reg_sel = REG_RET_HI; writable = aliased; end
            12'hC01, 12'hC81: begin reg_sel = REG_NONE; writable = 1'b0; end
            12'hF11, 12'hF12, 12'hF13, 12'hF14, 12'hF15:
                begin reg_sel = REG_INFO; writable = 1'b0; end
            default: reg_sel = REG_NONE;
        endcase
        illegal = (reg_sel == REG_NONE) || (is_write && !writable);
    end
endmodule

// File: rtl/mtrap_tval_sel.sv
module mtrap_tval_sel
    import mtrap_pkg::*;
#(
    parameter bit COMPRESSED_EN = 1'b1
) (
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    fault_addr,
    input  logic [XLEN-1:0]    insn,
    input  logic               insn_c,
    input  logic [XLEN-1:0]    subtype,
    output logic [XLEN-1:0]    tval
);
    localparam int HALF_W = XLEN / 2;

    logic [XLEN-1:0] insn_val;

    generate
        if (COMPRESSED_EN) begin : g_cmp
            always_comb
                insn_val = insn_c ? {{(XLEN-HALF_W){1'b0}}, insn[HALF_W-1:0]} : insn;
        end else begin : g_full
            always_comb insn_val = insn;
        end
    endgenerate

    always_comb begin
        case (cause)
            EXC_FETCH_ACC, EXC_LOAD_ACC, EXC_STORE_ACC: tval = fault_addr;
            EXC_ILLEGAL:                                tval = insn_val;
            EXC_SW_CHECK:                               tval = subtype;
            EXC_BREAK:                                  tval = '0;
            default:                                    tval = '0;
        endcase
    end
endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit
    import mtrap_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_VEC     = 32'h0000_0100,
    parameter bit              COMPRESSED_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_req,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_pc,
    input  logic [XLEN-1:0]    trap_addr,
    input  logic [XLEN-1:0]    trap_insn,
    input  logic               trap_insn_c,
    input  logic [XLEN-1:0]    trap_sub,
    input  logic               mret_req,
    input  logic               csr_valid,
    input  logic               csr_write,
    input  logic [ADDR_W-1:0]  csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    output logic               csr_illegal,
    output logic               st_mie,
    output logic               st_mpie,
    output logic               st_mdt,
    output logic [XLEN-1:0]    vec_base,
    output logic [1:0]         vec_mode,
    output logic               halted
);
    localparam int MODE_W = 2;

    trap_state_t     s_d, s_q;
    csr_reg_e        dec_sel;
    logic            dec_writable;
    logic            dec_illegal;
    logic [XLEN-1:0] tval_new;
    logic [XLEN-1:0] cause_ext;
    logic            do_write;

    mtrap_csr_decode u_dec (
        .addr     (csr_addr),
        .is_write (csr_write),
        .reg_sel  (dec_sel),
        .writable (dec_writable),
        .illegal  (dec_illegal)
    );

    mtrap_tval_sel #(.COMPRESSED_EN(COMPRESSED_EN)) u_tval (
        .cause      (trap_cause),
        .fault_addr (trap_addr),
        .insn       (trap_insn),
        .insn_c     (trap_insn_c),
        .subtype    (trap_sub),
        .tval       (tval_new)
    );

    // read path
    always_comb begin
        csr_rdata = '0;
        if (csr_valid) begin
            case (dec_sel)
                REG_STATUS: begin
                    csr_rdata[ST_MIE_B]             = s_q.mie;
                    csr_rdata[ST_MPIE_B]            = s_q.mpie;
                    csr_rdata[ST_MPP_LSB +: MODE_W] = s_q.mpp;
                end
                REG_STATUSH: begin
                    csr_rdata[STH_MBE_B] = s_q.mbe;
                    csr_rdata[STH_ELP_B] = s_q.mpelp;
                    csr_rdata[STH_MDT_B] = s_q.mdt;
                end
                REG_VECTOR:  csr_rdata = s_q.vector;
                REG_SCRATCH: csr_rdata = s_q.scratch;
                REG_EPC:     csr_rdata = s_q.epc;
                REG_CAUSE:   csr_rdata = s_q.cause;
                REG_TVAL:    csr_rdata = s_q.tval;
                REG_TVAL2:   csr_rdata = s_q.tval2;
                REG_CYC_LO:  csr_rdata = s_q.cyc_lo;
                REG_CYC_HI:  csr_rdata = s_q.cyc_hi;
                REG_RET_LO:  csr_rdata = s_q.ret_lo;
                REG_RET_HI:  csr_rdata = s_q.ret_hi;
                default:     csr_rdata = '0;
            endcase
        end
        csr_illegal = csr_valid && dec_illegal;
    end

    // next-state: trap, then mret, then CSR write
    always_comb begin
        s_d       = s_q;
        cause_ext = {{(XLEN-CAUSE_W){1'b0}}, trap_cause};
        do_write  = csr_valid && csr_write && dec_writable && !dec_illegal;
        if (trap_req) begin
            s_d.cause = cause_ext;
            s_d.epc   = trap_pc;
            s_d.tval  = tval_new;
            s_d.mpie  = s_q.mie;
            s_d.mie   = 1'b0;
            if (s_q.mdt) begin
                s_d.tval2  = cause_ext;
                s_d.halted = 1'b1;
            end else begin
                s_d.mdt = 1'b1;
            end
        end else if (mret_req) begin
            s_d.mdt  = 1'b0;
            s_d.mie  = s_q.mpie;
            s_d.mpie = 1'b1;
            s_d.mpp  = 2'b11;
        end else if (do_write) begin
            case (dec_sel)
                REG_STATUS: begin
                    s_d.mie  = csr_wdata[ST_MIE_B];
                    s_d.mpie = csr_wdata[ST_MPIE_B];
                    s_d.mpp  = csr_wdata[ST_MPP_LSB +: MODE_W];
                end
                REG_STATUSH: begin
                    s_d.mbe   = csr_wdata[STH_MBE_B];
                    s_d.mpelp = csr_wdata[STH_ELP_B];
                    s_d.mdt   = csr_wdata[STH_MDT_B];
                end
                REG_VECTOR:  s_d.vector  = csr_wdata;
                REG_SCRATCH: s_d.scratch = csr_wdata;
                REG_EPC:     s_d.epc     = csr_wdata;
                REG_CAUSE:   s_d.cause   = csr_wdata;
                REG_TVAL:    s_d.tval    = csr_wdata;
                REG_TVAL2:   s_d.tval2   = csr_wdata;
                REG_CYC_LO:  s_d.cyc_lo  = csr_wdata;
                REG_CYC_HI:  s_d.cyc_hi  = csr_wdata;
                REG_RET_LO:  s_d.ret_lo  = csr_wdata;
                REG_RET_HI:  s_d.ret_hi  = csr_wdata;
                default:     s_d         = s_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.vector <= RESET_VEC;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        st_mie   = s_q.mie;
        st_mpie  = s_q.mpie;
        st_mdt   = s_q.mdt;
        halted   = s_q.halted;
        vec_mode = s_q.vector[MODE_W-1:0];
        vec_base = {s_q.vector[XLEN-1:MODE_W], {MODE_W{1'b0}}};
    end
endmodule

// File: rtl/mtrap_csr_unit_chk.sv
module mtrap_csr_unit_chk
    import mtrap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              trap_req,
    input logic              mret_req,
    input logic              csr_valid,
    input logic              csr_write,
    input logic [ADDR_W-1:0] csr_addr,
    input logic              csr_illegal,
    input logic              st_mie,
    input logic              st_mpie,
    input logic              st_mdt,
    input logic              halted
);
    // R2
    trap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (!st_mie && (st_mpie == $past(st_mie))));

    // R6
    first_trap_mdt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !st_mdt && !halted) |=> (st_mdt && !halted));

    // R6
    double_trap_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && st_mdt) |=> halted);

    // R6
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R7
    mret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_req && !trap_req) |=> (!st_mdt && st_mpie && (st_mie == $past(st_mpie))));

    // R8
    ro_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_write &&
         ((csr_addr >= 12'hC00 && csr_addr <= 12'hC02) ||
          (csr_addr >= 12'hC80 && csr_addr <= 12'hC82) ||
          (csr_addr >= 12'hF11 && csr_addr <= 12'hF15))) |-> csr_illegal);
endmodule

bind mtrap_csr_unit mtrap_csr_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_req    (trap_req),
    .mret_req    (mret_req),
    .csr_valid   (csr_valid),
    .csr_write   (csr_write),
    .csr_addr    (csr_addr),
    .csr_illegal (csr_illegal),
    .st_mie      (st_mie),
    .st_mpie     (st_mpie),
    .st_mdt      (st_mdt),
    .halted      (halted)
);

// File: tb/mtrap_csr_unit_tb.sv
module mtrap_csr_unit_tb;
    import mtrap_pkg::*;

    localparam logic [XLEN-1:0] TB_VEC = 32'h0000_0A05;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               trap_req = 1'b0;
    logic [CAUSE_W-1:0] trap_cause = '0;
    logic [XLEN-1:0]    trap_pc = '0;
    logic [XLEN-1:0]    trap_addr = '0;
    logic [XLEN-1:0]    trap_insn = '0;
    logic               trap_insn_c = 1'b0;
    logic [XLEN-1:0]    trap_sub = '0;
    logic               mret_req = 1'b0;
    logic               csr_valid = 1'b0;
    logic               csr_write = 1'b0;
    logic [ADDR_W-1:0]  csr_addr = '0;
    logic [XLEN-1:0]    csr_wdata = '0;
    logic [XLEN-1:0]    csr_rdata;
    logic               csr_illegal;
    logic               st_mie, st_mpie, st_mdt, halted;
    logic [XLEN-1:0]    vec_base;
    logic [1:0]         vec_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mtrap_csr_unit #(.RESET_VEC(TB_VEC), .COMPRESSED_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .trap_req(trap_req), .trap_cause(trap_cause), .trap_pc(trap_pc),
        .trap_addr(trap_addr), .trap_insn(trap_insn), .trap_insn_c(trap_insn_c),
        .trap_sub(trap_sub), .mret_req(mret_req),
        .csr_valid(csr_valid), .csr_write(csr_write), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
        .st_mie(st_mie), .st_mpie(st_mpie), .st_mdt(st_mdt),
        .vec_base(vec_base), .vec_mode(vec_mode), .halted(halted)
    );

    typedef struct packed {
        logic            wr;
        logic [11:0]     addr;
        logic [31:0]     wdata;
        logic [31:0]     exp;
        logic            ill;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h305, 32'h0000_2003, 32'h0, 1'b0},          // R12 setup
        '{1'b0, 12'h305, 32'h0, 32'h0000_2003, 1'b0},
        '{1'b1, 12'h340, 32'hA5A5_0001, 32'h0, 1'b0},
        '{1'b0, 12'h340, 32'h0, 32'hA5A5_0001, 1'b0},
        '{1'b1, 12'hB00, 32'h1111_2222, 32'h0, 1'b0},          // R10
        '{1'b0, 12'hC00, 32'h0, 32'h1111_2222, 1'b0},          // R10
        '{1'b1, 12'hB82, 32'h3333_4444, 32'h0, 1'b0},          // R10
        '{1'b0, 12'hC82, 32'h0, 32'h3333_4444, 1'b0},          // R10
        '{1'b1, 12'hC02, 32'h0000_0005, 32'h0, 1'b1},          // R8
        '{1'b0, 12'hC02, 32'h0, 32'h0, 1'b0},                  // R8 unchanged
        '{1'b1, 12'hF12, 32'h0000_0007, 32'h0, 1'b1},          // R8
        '{1'b0, 12'hF12, 32'h0, 32'h0, 1'b0},                  // R8
        '{1'b0, 12'h7C0, 32'h0, 32'h0, 1'b1},                  // R9
        '{1'b1, 12'h7C0, 32'h1234_5678, 32'h0, 1'b1},          // R9
        '{1'b1, 12'h310, 32'hFFFF_FFFF, 32'h0, 1'b0},          // R11
        '{1'b0, 12'h310, 32'h0, 32'h0000_0620, 1'b0},          // R11
        '{1'b1, 12'h310, 32'h0, 32'h0, 1'b0},
        '{1'b0, 12'h310, 32'h0, 32'h0, 1'b0},
        '{1'b1, 12'h300, 32'hFFFF_FFFF, 32'h0, 1'b0},          // R11
        '{1'b0, 12'h300, 32'h0, 32'h0000_1888, 1'b0},          // R11
        '{1'b1, 12'h300, 32'h0, 32'h0, 1'b0},
        '{1'b0, 12'h300, 32'h0, 32'h0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // one cycle of stimulus; returns combinational CSR outputs sampled mid-cycle
    task automatic step(input logic tr, input logic [4:0] cause, input logic [31:0] pc,
                        input logic [31:0] addr, input logic [31:0] insn, input logic c,
                        input logic [31:0] sub, input logic mr,
                        input logic cv, input logic cw, input logic [11:0] ca,
                        input logic [31:0] cd,
                        output logic [31:0] rd, output logic ill);
        @(negedge clk);
        trap_req = tr; trap_cause = cause; trap_pc = pc; trap_addr = addr;
        trap_insn = insn; trap_insn_c = c; trap_sub = sub; mret_req = mr;
        csr_valid = cv; csr_write = cw; csr_addr = ca; csr_wdata = cd;
        #2;
        rd = csr_rdata; ill = csr_illegal;
        @(posedge clk);
        #1;
        trap_req = 1'b0; mret_req = 1'b0; csr_valid = 1'b0; csr_write = 1'b0;
    endtask

    task automatic csr_rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        logic [31:0] rd; logic ill;
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, a, 0, rd, ill);
        check(req, rd, exp);
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] rd; logic ill;
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, a, d, rd, ill);
    endtask

    task automatic do_trap(input logic [4:0] cause, input logic [31:0] pc,
                           input logic [31:0] addr, input logic [31:0] insn,
                           input logic c, input logic [31:0] sub);
        logic [31:0] rd; logic ill;
        step(1, cause, pc, addr, insn, c, sub, 0, 0, 0, 0, 0, rd, ill);
    endtask

    task automatic do_mret();
        logic [31:0] rd; logic ill;
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, rd, ill);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] rd;
        logic ill;
        do_reset();

        // R1 reset state
        csr_rd(12'h300, 32'h0, "R1 mstatus");
        csr_rd(12'h310, 32'h0, "R1 mstatush");
        csr_rd(12'h305, TB_VEC, "R1 vector");
        check("R1 halted", {31'b0, halted}, 32'h0);
        // R12 at reset
        check("R12 mode reset", {30'b0, vec_mode}, 32'h1);
        check("R12 base reset", vec_base, 32'h0000_0A04);

        // table walk
        for (int i = 0; i < NV; i++) begin
            step(0, 0, 0, 0, 0, 0, 0, 0, 1, VECS[i].wr, VECS[i].addr, VECS[i].wdata, rd, ill);
            check($sformatf("R8/R9 illegal row %0d", i), {31'b0, ill}, {31'b0, VECS[i].ill});
            if (!VECS[i].wr)
                check($sformatf("R9/R10/R11 rdata row %0d", i), rd, VECS[i].exp);
        end
        check("R12 mode", {30'b0, vec_mode}, 32'h3);
        check("R12 base", vec_base, 32'h0000_2000);

        // R2/R3 load access fault with MIE set
        csr_wr(12'h300, 32'h0000_0008);
        do_trap(5'd5, 32'h0000_0040, 32'hDEAD_0000, 32'hFFFF_FFFF, 1'b0, 32'h9);
        check("R2 mie", {31'b0, st_mie}, 32'h0);
        check("R2 mpie", {31'b0, st_mpie}, 32'h1);
        check("R6 mdt set", {31'b0, st_mdt}, 32'h1);
        check("R6 no halt", {31'b0, halted}, 32'h0);
        csr_rd(12'h341, 32'h0000_0040, "R2 epc");
        csr_rd(12'h342, 32'h0000_0005, "R2 cause");
        csr_rd(12'h343, 32'hDEAD_0000, "R3 tval load");

        // R7 mret
        do_mret();
        check("R7 mdt", {31'b0, st_mdt}, 32'h0);
        check("R7 mie", {31'b0, st_mie}, 32'h1);
        check("R7 mpie", {31'b0, st_mpie}, 32'h1);
        csr_rd(12'h300, 32'h0000_1888, "R7 mpp");

        // R4 compressed and full illegal instruction
        do_trap(5'd2, 32'h44, 32'h1, 32'hABCD_1234, 1'b1, 32'h0);
        csr_rd(12'h343, 32'h0000_1234, "R4 compressed");
        do_mret();
        do_trap(5'd2, 32'h48, 32'h1, 32'hABCD_1234, 1'b0, 32'h0);
        csr_rd(12'h343, 32'hABCD_1234, "R4 full");
        do_mret();

        // R3 fetch and store faults
        do_trap(5'd1, 32'h4C, 32'h0002_0000, 32'h5, 1'b0, 32'h6);
        csr_rd(12'h343, 32'h0002_0000, "R3 fetch");
        do_mret();
        do_trap(5'd7, 32'h50, 32'h0003_0004, 32'h5, 1'b0, 32'h6);
        csr_rd(12'h343, 32'h0003_0004, "R3 store");
        do_mret();

        // R5 breakpoint, software check, other
        do_trap(5'd3, 32'h54, 32'h7777_7777, 32'h8888_8888, 1'b0, 32'h9);
        csr_rd(12'h343, 32'h0, "R5 break");
        do_mret();
        do_trap(5'd18, 32'h58, 32'h7777_7777, 32'h8888_8888, 1'b0, 32'h2);
        csr_rd(12'h343, 32'h0000_0002, "R5 swcheck");
        do_mret();
        do_trap(5'd11, 32'h5C, 32'h7777_7777, 32'h8888_8888, 1'b0, 32'h2);
        csr_rd(12'h343, 32'h0, "R5 other");
        do_mret();

        // R13 trap beats mret and CSR write
        step(1, 5'd11, 32'h60, 0, 0, 0, 0, 1, 1, 1, 12'h340, 32'h77, rd, ill);
        check("R13 trap wins mdt", {31'b0, st_mdt}, 32'h1);
        csr_rd(12'h340, 32'hA5A5_0001, "R13 write dropped by trap");
        csr_rd(12'h341, 32'h60, "R13 epc");
        // R13 mret beats CSR write
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 12'h340, 32'h77, rd, ill);
        check("R13 mret applied", {31'b0, st_mdt}, 32'h0);
        csr_rd(12'h340, 32'hA5A5_0001, "R13 write dropped by mret");

        // R6 double trap
        do_trap(5'd5, 32'h64, 32'h10, 0, 0, 0);
        check("R6 first no halt", {31'b0, halted}, 32'h0);
        do_trap(5'd7, 32'h68, 32'h20, 0, 0, 0);
        check("R6 halted", {31'b0, halted}, 32'h1);
        csr_rd(12'h34B, 32'h7, "R6 tval2");
        do_mret();
        csr_wr(12'h310, 32'h0);
        check("R6 sticky", {31'b0, halted}, 32'h1);
        do_reset();
        #1;
        check("R1 halt cleared", {31'b0, halted}, 32'h0);
        csr_rd(12'h34B, 32'h0, "R1 tval2 reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule